// File: doc/BRIEF.md
# Mixed-Width Circular Data FIFO

This block is the byte store that sits between a processor-visible data port and a memory-card data path. Sixty-four bytes live in a circular buffer described by a read pointer and a fill count. The processor reaches the store through a single request port. Each request carries a width code, so one access moves one, two or four bytes. Multi-byte data is packed little-endian, with the oldest byte in the low lane. The card side moves one byte per cycle. It pushes bytes while the transfer mode is receive and pops them while the mode is transmit.

The block also produces a fourteen-bit status word that depends on the transfer mode, and one-cycle event pulses. Those pulses mark fill-level crossings, rejected reads (underrun) and rejected pushes (overflow). A five-bit control input is held in a register, and one of its bits empties the store. A card operation and a processor access may arrive in the same cycle, and the block merges them in a fixed order.

Top module: `sd_byte_fifo`

## Requirements
- R1: After reset the fill count is 0, `fifo_status` is 0 in idle mode (`xfer_mode` 0 or 1), `cpu_rdata` is 0, `ctrl_q` is 0 and all event pulses are low.
- R2: With `cpu_req` high, `cpu_size` 0, 1 and 2/3 move 1, 2 and 4 bytes. A write pushes `cpu_wdata` bits 7:0 first, then 15:8, 23:16 and 31:24. A read returns the popped bytes on `cpu_rdata` one cycle later, with the oldest byte in bits 7:0 and unused lanes zero. `cpu_rdata` is 0 in any cycle that follows no successful read.
- R3: Storage is addressed modulo 64, so byte order is kept across any number of pointer wrap-arounds.
- R4: A read that asks for more bytes than are available pops nothing and returns 0. In the next cycle `underrun` is high for one cycle.
- R5: A push that does not fit is dropped whole and pulses `overflow` in the next cycle. This covers a processor write larger than the free space, and a card push in receive mode with 64 bytes held. The count never exceeds 64.
- R6: A `ctrl_we` cycle stores `ctrl_wdata & 5'b11101` in `ctrl_q`. If `ctrl_wdata[1]` is set, the count becomes 0, and every other FIFO operation in that cycle has no effect and raises no pulse.
- R7: In receive mode (`xfer_mode` 2), `fifo_status` holds these fields. Bits 6:0 are the count. Bit 7 is count > 31 and bit 8 is count > 63. Bit 9 copies `blocks_done`. Bits 11:10 read 2'b11. Bit 12 is count != 0 and bit 13 is 0.
- R8: In transmit mode (`xfer_mode` 3), `fifo_status` holds these fields. Bits 6:0 are the count. Bit 10 is count == 0 and bit 11 is count < 33. Bit 13 is count < 64, and bits 12 and 9:7 are 0. In idle mode only bits 6:0 (the count) are non-zero.
- R9: In receive mode, `irq_rx_half` pulses in the cycle after the count moves from below 32 to 32 or more. `irq_rx_full` pulses in the cycle after the count moves from below 64 to exactly 64.
- R10: In transmit mode, `irq_tx_empty` pulses in the cycle after the count moves from non-zero to zero. `irq_tx_half` pulses in the cycle after it moves from above 32 to 32 or below.
- R11: `card_rdata` always shows the oldest byte. A card pop takes effect only in transmit mode with the count non-zero. A card push takes effect only in receive mode. Otherwise card operations leave the store unchanged.
- R12: In one cycle, a card pop is served before a processor read, so the read starts at the second-oldest byte and is checked against count-1. A card push is served before a processor write, which lands behind it and is checked against the space left after the push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor data access this cycle |
| cpu_we | input | 1 | 1 = write (push), 0 = read (pop) |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| cpu_wdata | input | 32 | Write data, little-endian lanes |
| cpu_rdata | output | 32 | Read data, one cycle after the request |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 5 | Control write value; bit 1 flushes |
| ctrl_q | output | 5 | Stored control value |
| xfer_mode | input | 2 | 0/1 idle, 2 receive, 3 transmit |
| blocks_done | input | 1 | Block counters exhausted (receive status) |
| card_push | input | 1 | Card pushes `card_wdata` |
| card_wdata | input | 8 | Byte from the card |
| card_pop | input | 1 | Card takes the oldest byte |
| card_rdata | output | 8 | Oldest byte |
| fifo_status | output | 14 | Mode-dependent status word |
| underrun | output | 1 | Rejected read pulse |
| overflow | output | 1 | Rejected push pulse |
| irq_rx_half | output | 1 | Receive half crossing pulse |
| irq_rx_full | output | 1 | Receive full crossing pulse |
| irq_tx_empty | output | 1 | Transmit empty crossing pulse |
| irq_tx_half | output | 1 | Transmit half crossing pulse |

## Verification
A card pop can meet a processor read in the same cycle, and a card push can meet a processor write. A flush can meet either pair. Directed cycles force each pairing at awkward fill levels: a pop plus a word read with exactly four bytes held, and a card push plus a write that fits only without the card byte. Random cycles then raise both strobes together often. A byte-queue model in the bench serves the card operation first and the processor second, and it is the judge of read data, count, status and pulses in every such cycle.

// File: rtl/sd_byte_fifo.sv
module sd_byte_fifo #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  input  logic        ctrl_we,
  input  logic [4:0]  ctrl_wdata,
  output logic [4:0]  ctrl_q,
  input  logic [1:0]  xfer_mode,
  input  logic        blocks_done,
  input  logic        card_push,
  input  logic [7:0]  card_wdata,
  input  logic        card_pop,
  output logic [7:0]  card_rdata,
  output logic [13:0] fifo_status,
  output logic        underrun,
  output logic        overflow,
  output logic        irq_rx_half,
  output logic        irq_rx_full,
  output logic        irq_tx_empty,
  output logic        irq_tx_half
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rptr;
  logic [CW-1:0] cnt, cnt_nxt;
  logic [2:0]    nb;
  logic [31:0]   rd_word;

  wire is_rx = (xfer_mode == 2'd2);
  wire is_tx = (xfer_mode == 2'd3);
  wire flush = ctrl_we & ctrl_wdata[1];

  always_comb begin
    case (cpu_size)
      2'd0:    nb = 3'd1;
      2'd1:    nb = 3'd2;
      default: nb = 3'd4;
    endcase
  end

  wire pop_c  = ~flush & card_pop & is_tx & (cnt != '0);
  wire push_c = ~flush & card_push & is_rx & (cnt != FULL);

  wire [CW-1:0] avail = cnt - CW'(pop_c);
  wire [CW-1:0] space = FULL - cnt - CW'(push_c);

  wire rd_try = ~flush & cpu_req & ~cpu_we;
  wire wr_try = ~flush & cpu_req & cpu_we;
  wire rd_ok  = rd_try & (CW'(nb) <= avail);
  wire wr_ok  = wr_try & (CW'(nb) <= space);
  wire rd_bad = rd_try & ~rd_ok;
  wire wr_bad = (wr_try & ~wr_ok) | (~flush & card_push & is_rx & (cnt == FULL));

  wire [AW-1:0] rbase = rptr + AW'(pop_c);
  wire [AW-1:0] wcard = rptr + cnt[AW-1:0];
  wire [AW-1:0] wbase = wcard + AW'(push_c);

  always_comb begin
    for (int i = 0; i < 4; i++)
      rd_word[8*i +: 8] = (3'(i) < nb) ? mem[rbase + AW'(i)] : 8'h00;
  end

  always_comb begin
    if (flush)
      cnt_nxt = '0;
    else
      cnt_nxt = cnt - CW'(pop_c) - (rd_ok ? CW'(nb) : '0)
                    + CW'(push_c) + (wr_ok ? CW'(nb) : '0);
  end

  always_ff @(posedge clk) begin
    if (push_c) mem[wcard] <= card_wdata;
    if (wr_ok)
      for (int i = 0; i < 4; i++)
        if (3'(i) < nb) mem[wbase + AW'(i)] <= cpu_wdata[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr         <= '0;
      cnt          <= '0;
      cpu_rdata    <= '0;
      ctrl_q       <= '0;
      underrun     <= 1'b0;
      overflow     <= 1'b0;
      irq_rx_half  <= 1'b0;
      irq_rx_full  <= 1'b0;
      irq_tx_empty <= 1'b0;
      irq_tx_half  <= 1'b0;
    end else begin
      if (!flush) rptr <= rptr + AW'(pop_c) + (rd_ok ? AW'(nb) : '0);
      cnt          <= cnt_nxt;
      cpu_rdata    <= rd_ok ? rd_word : '0;
      if (ctrl_we) ctrl_q <= ctrl_wdata & 5'b11101;
      underrun     <= rd_bad;
      overflow     <= wr_bad;
      irq_rx_half  <= is_rx & (cnt < HALF) & (cnt_nxt >= HALF);
      irq_rx_full  <= is_rx & (cnt < FULL) & (cnt_nxt == FULL);
      irq_tx_empty <= is_tx & (cnt != '0) & (cnt_nxt == '0);
      irq_tx_half  <= is_tx & (cnt > HALF) & (cnt_nxt <= HALF);
    end
  end

  assign card_rdata = mem[rptr];

  always_comb begin
    fifo_status      = '0;
    fifo_status[6:0] = 7'(cnt);
    if (is_rx) begin
      fifo_status[7]     = cnt >= HALF;
      fifo_status[8]     = cnt == FULL;
      fifo_status[9]     = blocks_done;
      fifo_status[11:10] = 2'b11;
      fifo_status[12]    = cnt != '0;
    end else if (is_tx) begin
      fifo_status[10] = cnt == '0;
      fifo_status[11] = cnt <= HALF;
      fifo_status[13] = cnt < FULL;
    end
  end
endmodule

// File: rtl/sd_byte_fifo_chk.sv
module sd_byte_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          ctrl_we,
  input logic [4:0]    ctrl_wdata,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic          card_pop,
  input logic [1:0]    xfer_mode,
  input logic          underrun,
  input logic [31:0]   cpu_rdata,
  input logic          irq_rx_full,
  input logic          irq_tx_empty
);
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R4
  underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> cpu_rdata == 32'h0);

  // R6
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[1]) |=> cnt == '0);

  // R9
  rx_full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_full |-> cnt == CW'(DEPTH));

  // R10
  tx_empty_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_empty |-> cnt == '0);

  // R11
  empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_pop && xfer_mode == 2'd3 && cnt == '0 && !(cpu_req && cpu_we))
      |=> cnt == '0);
endmodule

bind sd_byte_fifo sd_byte_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .ctrl_we(ctrl_we),
  .ctrl_wdata(ctrl_wdata), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .card_pop(card_pop), .xfer_mode(xfer_mode), .underrun(underrun),
  .cpu_rdata(cpu_rdata), .irq_rx_full(irq_rx_full),
  .irq_tx_empty(irq_tx_empty)
);

// File: tb/sd_byte_fifo_bench.sv
module sd_byte_fifo_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0, ctrl_we = 0, blocks_done = 0;
  logic card_push = 0, card_pop = 0;
  logic [1:0] cpu_size = 0, xfer_mode = 0;
  logic [31:0] cpu_wdata = 0, cpu_rdata;
  logic [4:0] ctrl_wdata = 0, ctrl_q;
  logic [7:0] card_wdata = 0, card_rdata;
  logic [13:0] fifo_status;
  logic underrun, overflow, irq_rx_half, irq_rx_full, irq_tx_empty, irq_tx_half;

  always #10 clk = ~clk;

  sd_byte_fifo u_sd_byte_fifo (.*);

  int checks = 0, fails = 0;
  byte unsigned q[$];

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [13:0] exp_st(int c, logic [1:0] m, logic l);
    logic [13:0] s = '0;
    s[6:0] = 7'(c);
    if (m == 2'd2) begin
      s[7] = c > 31; s[8] = c > 63; s[9] = l; s[11:10] = 2'b11; s[12] = c != 0;
    end else if (m == 2'd3) begin
      s[10] = c == 0; s[11] = c < 33; s[13] = c < 64;
    end
    return s;
  endfunction

  task automatic step(input string tag, input bit rq, input bit we, input logic [1:0] sz,
                      input logic [31:0] wd, input bit cw, input logic [4:0] cd,
                      input logic [1:0] md, input bit lst, input bit cpsh,
                      input logic [7:0] cpd, input bit cpop);
    int old, n, space;
    bit unr, ovf, pc, pu;
    logic [31:0] rd;
    logic [5:0] fl;
    @(negedge clk);
    cpu_req = rq; cpu_we = we; cpu_size = sz; cpu_wdata = wd; ctrl_we = cw; ctrl_wdata = cd;
    xfer_mode = md; blocks_done = lst; card_push = cpsh; card_wdata = cpd; card_pop = cpop;
    #1;
    old = q.size();
    if (old > 0) chk(tag, "card_rdata head", 32'(card_rdata), 32'(q[0]));
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    unr = 0; ovf = 0; rd = 0;
    if (cw && cd[1]) q.delete();
    else begin
      pc = cpop && md == 2'd3 && old > 0;
      if (pc) void'(q.pop_front());
      if (rq && !we) begin
        if (n <= q.size()) for (int i = 0; i < n; i++) rd[8*i +: 8] = q.pop_front();
        else unr = 1;
      end
      pu = cpsh && md == 2'd2 && old < 64;
      if (cpsh && md == 2'd2 && old == 64) ovf = 1;
      if (pu) q.push_back(cpd);
      space = 64 - old - int'(pu);
      if (rq && we) begin
        if (n <= space) for (int i = 0; i < n; i++) q.push_back(wd[8*i +: 8]);
        else ovf = 1;
      end
    end
    fl[5] = unr; fl[4] = ovf;
    fl[3] = md == 2'd2 && old < 32 && q.size() >= 32;
    fl[2] = md == 2'd2 && old < 64 && q.size() == 64;
    fl[1] = md == 2'd3 && old != 0 && q.size() == 0;
    fl[0] = md == 2'd3 && old > 32 && q.size() <= 32;
    @(posedge clk); #1;
    chk(tag, "cpu_rdata", cpu_rdata, rd);
    chk(tag, "pulses", 32'({underrun, overflow, irq_rx_half, irq_rx_full, irq_tx_empty, irq_tx_half}), 32'(fl));
    chk(tag, "fifo_status", 32'(fifo_status), 32'(exp_st(q.size(), md, lst)));
    if (cw) chk(tag, "ctrl_q", 32'(ctrl_q), 32'(cd & 5'b11101));
  endtask

  task automatic cpuw(input string t, input logic [1:0] m, input logic [1:0] sz, input logic [31:0] d);
    step(t, 1, 1, sz, d, 0, 0, m, 0, 0, 0, 0);
  endtask
  task automatic cpur(input string t, input logic [1:0] m, input logic [1:0] sz);
    step(t, 1, 0, sz, 0, 0, 0, m, 0, 0, 0, 0);
  endtask
  task automatic flush(input string t);
    step(t, 0, 0, 0, 0, 1, 5'b00010, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "status", 32'(fifo_status), 0);
    chk("R1", "rdata", cpu_rdata, 0);
    chk("R1", "ctrl_q", 32'(ctrl_q), 0);
    chk("R1", "pulses", 32'({underrun, overflow, irq_rx_half, irq_rx_full, irq_tx_empty, irq_tx_half}), 0);
    rst_n = 1'b1;
    // R2 little-endian mixed widths
    cpuw("R2", 0, 2, 32'h44332211);
    cpuw("R2", 0, 1, 32'hFFFFBBAA);
    cpuw("R2", 0, 0, 32'hFFFFFFCC);
    cpur("R2", 0, 0);
    cpur("R2", 0, 1);
    cpur("R2", 0, 2);
    // R4 underrun with 3 bytes held
    cpuw("R4", 0, 1, 32'h0000BEEF);
    cpuw("R4", 0, 0, 32'h00000077);
    cpur("R4", 0, 2);
    cpur("R4", 0, 1);
    cpur("R4", 0, 1);
    // R6 flush and control mask
    step("R6", 0, 0, 0, 0, 1, 5'b11111, 0, 0, 0, 0, 0);
    step("R6", 1, 1, 2, 32'h12345678, 1, 5'b00010, 3, 0, 0, 0, 0);
    // R9 / R7 receive fill by card up to full, then overflow R5
    for (int i = 0; i < 65; i++) step("R9", 0, 0, 0, 0, 0, 0, 2, i[0], 1, 8'(i * 3), 0);
    step("R5", 1, 1, 0, 32'h1, 0, 0, 2, 1, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 2, 1, 0, 0, 0);
    // R11 pop ignored in receive, push ignored in transmit
    step("R11", 0, 0, 0, 0, 0, 0, 2, 0, 0, 0, 1);
    for (int i = 0; i < 16; i++) cpur("R3", 2, 2);
    step("R11", 0, 0, 0, 0, 0, 0, 3, 0, 1, 8'h5A, 0);
    step("R11", 0, 0, 0, 0, 0, 0, 3, 0, 0, 0, 1);
    // R10 / R8 transmit: fill by CPU, drain by card
    for (int i = 0; i < 17; i++) cpuw("R8", 3, 2, 32'hA5000000 | 32'(i));
    for (int i = 0; i < 65; i++) step("R10", 0, 0, 0, 0, 0, 0, 3, 0, 0, 0, 1);
    // R12 same-cycle pairings
    cpuw("R12", 3, 2, 32'hD4C3B2A1);
    step("R12", 1, 0, 2, 0, 0, 0, 3, 0, 0, 0, 1);
    cpuw("R12", 3, 0, 32'h11);
    cpuw("R12", 3, 0, 32'h22);
    step("R12", 1, 0, 0, 0, 0, 0, 3, 0, 0, 0, 1);
    flush("R6");
    for (int i = 0; i < 15; i++) cpuw("R12", 2, 2, 32'hC0DE0000 | 32'(i));
    cpuw("R12", 2, 1, 32'h00009988);
    step("R12", 1, 1, 1, 32'h00007766, 0, 0, 2, 0, 1, 8'hEE, 0);
    step("R12", 1, 1, 0, 32'h00000055, 0, 0, 2, 0, 1, 8'hDD, 0);
    flush("R6");
    // R3 wrap with random traffic
    for (int i = 0; i < 6000; i++) begin
      logic [1:0] md = (i % 1000 < 500) ? 2'd2 : 2'd3;
      bit rq = ($urandom % 3) != 0;
      bit we = (md == 2'd3) ? (($urandom % 4) != 0) : (($urandom % 3) == 0);
      bit cw = ($urandom % 97) == 0;
      step("R3", rq, we, 2'($urandom), $urandom, cw, 5'($urandom), md,
           1'($urandom), ($urandom % 2) == 0, 8'($urandom), ($urandom % 3) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule